// File: doc/BRIEF.md
# Fully Associative Translation Buffer Fill Unit

This block keeps a 64-slot, fully associative table of translation entries. Each slot holds a tag and a 64-bit data word. The data word carries its own valid flag and lock flag. Software changes the table through a single register-style write port, which takes one of three operations per cycle.

- A fill ("data-in") places the current tag-access register value and the supplied data word into a slot. The slot is chosen by a replacement policy: the lowest-numbered empty slot first, then the lowest-numbered unlocked slot. If every slot is valid and locked, the write is dropped.
- A direct slot write places the same pair at the slot named by address bits 8:3.
- A register write updates a small bank of status registers. The bank holds the tag-access register and a fault status/address pair that a hardware fault report can also load.

Three read ports answer one cycle after the request:
- a tag search, which returns the first valid entry whose tag equals the key;
- a register read;
- an entry read by slot index.

The searches are single-cycle priority encoders over the valid, lock and match vectors. Translation itself, table walking and demap are handled elsewhere.

Top module: `tlb_fill_unit`

## Requirements
- R1: After reset every slot is invalid, every status register reads zero and all registered outputs are zero.
- R2: Bit 63 of an entry's data word is its valid flag and bit 6 is its lock flag; the entry read returns the stored word, with bit 63 cleared for every slot invalidated by reset.
- R3: A fill (wr_op 2'b01) writes the tag-access register value as tag and wr_data as data into the lowest-numbered slot whose valid flag is clear.
- R4: When no slot is invalid, a fill overwrites the lowest-numbered slot whose lock flag is clear; when every slot is valid and locked, the fill changes nothing.
- R5: A direct slot write (wr_op 2'b10) writes the tag-access value and wr_data into the slot given by wr_addr[8:3]; wr_op 2'b11 changes nothing.
- R6: A tag search returns hit=1, the lowest-numbered valid slot whose tag equals the key, and that tag; on a miss it returns hit=0, index 0 and tag 0.
- R7: A register write (wr_op 2'b00) selects register wr_addr[6:3]; register 6 is the tag-access register; writes to registers 0 and 4 are ignored; other registers store the written value.
- R8: Writing register 3 (fault status) with bit 0 clear zeroes registers 3 and 4; with bit 0 set register 3 takes the written value and register 4 is unchanged.
- R9: A fault report loads register 3 with the reported status and register 4 with the reported address, and takes precedence over a same-cycle software write to those registers.
- R10: Search, register-read and entry-read results appear on registered outputs on the cycle after their request, reflect the table before any same-cycle write, and hold their values while no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write operation strobe |
| wr_op | input | 2 | 00 register write, 01 fill, 10 direct slot write, 11 no operation |
| wr_addr | input | 6 | Address bits 8:3; slot index for slot writes, bits 6:3 register select |
| wr_data | input | 64 | Write value or entry data word |
| flt_set | input | 1 | Fault report strobe |
| flt_stat | input | 64 | Reported fault status |
| flt_addr | input | 64 | Reported fault address |
| lk_en | input | 1 | Tag search request |
| lk_key | input | 64 | Tag to search for |
| lk_hit | output | 1 | Search found a valid match |
| lk_idx | output | 6 | Slot of the first match, 0 on miss |
| lk_tag | output | 64 | Matching tag, 0 on miss |
| rr_en | input | 1 | Register read request |
| rr_addr | input | 4 | Address bits 6:3 selecting the register |
| rr_data | output | 64 | Register read value |
| er_en | input | 1 | Entry read request |
| er_idx | input | 6 | Slot to read |
| er_tag | output | 64 | Tag of the read slot |
| er_data | output | 64 | Data word of the read slot |

## Verification
The bench fills the whole table with locked entries except two unlocked holes. Fills must then land in the lower hole first, then in the upper hole, and must then be dropped. A design that searched from the top, ignored the lock flag or overwrote a locked slot would place a tag where the entry reads and searches do not expect it. Duplicate tags are placed in two slots, and one of them is then invalidated, to catch a search that returns the wrong match or that matches invalid entries. Fault-status writes with bit 0 set and clear, and a fault report arriving in the same cycle as a software write, catch a register bank that clears too much, too little, or lets software win. A random phase compares every output on every clock with a behavioural model.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;
  typedef enum logic [1:0] {
    OP_REG  = 2'b00,
    OP_FILL = 2'b01,
    OP_SLOT = 2'b10,
    OP_NONE = 2'b11
  } wr_op_e;
endpackage

// File: rtl/tlbf_prio_pick.sv
// Lowest-index-first picker over a request vector.
module tlbf_prio_pick #(
  parameter int unsigned N  = 64,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tlbf_regfile.sv
// Status register bank: tag-access, fault status/address and general registers.
module tlbf_regfile #(
  parameter int unsigned NREGS      = 16,
  parameter int unsigned DW         = 64,
  parameter int unsigned TAGACC_REG = 6,
  parameter int unsigned FSTAT_REG  = 3,
  parameter int unsigned FADDR_REG  = 4,
  parameter int unsigned RO_REG     = 0,
  localparam int unsigned RW       = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          flt_set,
  input  logic [DW-1:0] flt_stat,
  input  logic [DW-1:0] flt_addr,
  input  logic          rd_en,
  input  logic [RW-1:0] rd_sel,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] tag_acc
);
  logic [DW-1:0] regs_q [NREGS];

  localparam logic [RW-1:0] SEL_FSTAT = RW'(FSTAT_REG);
  localparam logic [RW-1:0] SEL_FADDR = RW'(FADDR_REG);
  localparam logic [RW-1:0] SEL_RO    = RW'(RO_REG);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREGS; r++) regs_q[r] <= '0;
      rd_data <= '0;
    end else begin
      if (rd_en) rd_data <= regs_q[rd_sel];
      if (wr_en) begin
        if (wr_sel == SEL_FSTAT) begin
          if (!wr_data[0]) begin
            regs_q[FSTAT_REG] <= '0;
            regs_q[FADDR_REG] <= '0;
          end else begin
            regs_q[FSTAT_REG] <= wr_data;
          end
        end else if (wr_sel != SEL_RO && wr_sel != SEL_FADDR) begin
          regs_q[wr_sel] <= wr_data;
        end
      end
      if (flt_set) begin
        regs_q[FSTAT_REG] <= flt_stat;
        regs_q[FADDR_REG] <= flt_addr;
      end
    end
  end

  assign tag_acc = regs_q[TAGACC_REG];

  AST_RO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_RO) |=> $stable(regs_q[RO_REG])); // R7

  AST_FSTAT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_FSTAT && !wr_data[0] && !flt_set)
      |=> (regs_q[FSTAT_REG] == '0 && regs_q[FADDR_REG] == '0)); // R8

  AST_FAULT_WINS: assert property (@(posedge clk) disable iff (rst)
    flt_set |=> (regs_q[FSTAT_REG] == $past(flt_stat)
                 && regs_q[FADDR_REG] == $past(flt_addr))); // R9
endmodule

// File: rtl/tlbf_entry_store.sv
// Tag flops for parallel compare, data words in an inferable RAM,
// valid/lock flags mirrored into vectors for the pickers.
module tlbf_entry_store #(
  parameter int unsigned ENTRIES   = 64,
  parameter int unsigned TAG_W     = 64,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned VALID_BIT = 63,
  parameter int unsigned LOCK_BIT  = 6,
  localparam int unsigned IDX_W    = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IDX_W-1:0]   w_idx,
  input  logic [TAG_W-1:0]   w_tag,
  input  logic [DATA_W-1:0]  w_data,
  input  logic [TAG_W-1:0]   srch_tag,
  input  logic               er_en,
  input  logic [IDX_W-1:0]   er_idx,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] lock_vec,
  output logic [ENTRIES-1:0] match_vec,
  output logic [TAG_W-1:0]   er_tag,
  output logic [DATA_W-1:0]  er_data
);
  logic [TAG_W-1:0]   tags_q   [ENTRIES];
  logic [DATA_W-1:0]  data_mem [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] lock_q;
  logic [DATA_W-1:0]  er_raw_q;
  logic               er_valid_q;

  // RAM-style storage: single write port, registered read, no reset.
  always_ff @(posedge clk) begin
    if (we) begin
      data_mem[w_idx] <= w_data;
      tags_q[w_idx]   <= w_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      er_raw_q <= '0;
      er_tag   <= '0;
    end else if (er_en) begin
      er_raw_q <= data_mem[er_idx];
      er_tag   <= tags_q[er_idx];
    end
  end

  // Flag vectors carry reset; valid bit of the read word is taken from here.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q    <= '0;
      lock_q     <= '0;
      er_valid_q <= 1'b0;
    end else begin
      if (er_en) er_valid_q <= valid_q[er_idx];
      if (we) begin
        valid_q[w_idx] <= w_data[VALID_BIT];
        lock_q[w_idx]  <= w_data[LOCK_BIT];
      end
    end
  end

  always_comb begin
    er_data            = er_raw_q;
    er_data[VALID_BIT] = er_valid_q;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match_vec[e] = valid_q[e] && (tags_q[e] == srch_tag);
  end

  assign valid_vec = valid_q;
  assign lock_vec  = lock_q;

  AST_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    we |=> (valid_q[$past(w_idx)] == $past(w_data[VALID_BIT])
            && lock_q[$past(w_idx)] == $past(w_data[LOCK_BIT]))); // R2

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(valid_q) && $stable(lock_q))); // R5
endmodule

// File: rtl/tlb_fill_unit.sv
module tlb_fill_unit #(
  parameter int unsigned ENTRIES    = 64,
  parameter int unsigned TAG_W      = 64,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned VALID_BIT  = 63,
  parameter int unsigned LOCK_BIT   = 6,
  parameter int unsigned NREGS      = 16,
  parameter int unsigned ADDR_LSB   = 3,
  parameter int unsigned TAGACC_REG = 6,
  parameter int unsigned FSTAT_REG  = 3,
  parameter int unsigned FADDR_REG  = 4,
  parameter int unsigned RO_REG     = 0,
  localparam int unsigned IDX_W     = $clog2(ENTRIES),
  localparam int unsigned REG_W     = $clog2(NREGS),
  localparam int unsigned ADDR_MSB  = ADDR_LSB + IDX_W - 1,
  localparam int unsigned REG_MSB   = ADDR_LSB + REG_W - 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [1:0]                   wr_op,
  input  logic [ADDR_MSB:ADDR_LSB]     wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         flt_set,
  input  logic [DATA_W-1:0]            flt_stat,
  input  logic [DATA_W-1:0]            flt_addr,
  input  logic                         lk_en,
  input  logic [TAG_W-1:0]             lk_key,
  output logic                         lk_hit,
  output logic [IDX_W-1:0]             lk_idx,
  output logic [TAG_W-1:0]             lk_tag,
  input  logic                         rr_en,
  input  logic [REG_MSB:ADDR_LSB]      rr_addr,
  output logic [DATA_W-1:0]            rr_data,
  input  logic                         er_en,
  input  logic [IDX_W-1:0]             er_idx,
  output logic [TAG_W-1:0]             er_tag,
  output logic [DATA_W-1:0]            er_data
);
  import tlbf_pkg::*;

  wr_op_e op;
  logic   do_reg, do_fill, do_slot;

  assign op      = wr_op_e'(wr_op);
  assign do_reg  = wr_en && (op == OP_REG);
  assign do_fill = wr_en && (op == OP_FILL);
  assign do_slot = wr_en && (op == OP_SLOT);

  logic [ENTRIES-1:0] valid_vec, lock_vec, match_vec;
  logic               inv_found, unl_found, hit_found;
  logic [IDX_W-1:0]   inv_idx, unl_idx, hit_idx;
  logic [DATA_W-1:0]  tag_acc;
  logic               st_we;
  logic [IDX_W-1:0]   st_idx;
  logic [IDX_W-1:0]   slot_sel;

  assign slot_sel = wr_addr[ADDR_LSB +: IDX_W];

  tlbf_prio_pick #(.N(ENTRIES)) u_pick_inv (
    .req(~valid_vec), .found(inv_found), .idx(inv_idx));

  tlbf_prio_pick #(.N(ENTRIES)) u_pick_unl (
    .req(~lock_vec), .found(unl_found), .idx(unl_idx));

  tlbf_prio_pick #(.N(ENTRIES)) u_pick_hit (
    .req(match_vec), .found(hit_found), .idx(hit_idx));

  assign st_we  = do_slot || (do_fill && (inv_found || unl_found));
  assign st_idx = do_slot   ? slot_sel :
                  inv_found ? inv_idx  : unl_idx;

  tlbf_entry_store #(
    .ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W),
    .VALID_BIT(VALID_BIT), .LOCK_BIT(LOCK_BIT)
  ) u_store (
    .clk(clk), .rst(rst),
    .we(st_we), .w_idx(st_idx), .w_tag(tag_acc[TAG_W-1:0]), .w_data(wr_data),
    .srch_tag(lk_key),
    .er_en(er_en), .er_idx(er_idx),
    .valid_vec(valid_vec), .lock_vec(lock_vec), .match_vec(match_vec),
    .er_tag(er_tag), .er_data(er_data)
  );

  tlbf_regfile #(
    .NREGS(NREGS), .DW(DATA_W), .TAGACC_REG(TAGACC_REG),
    .FSTAT_REG(FSTAT_REG), .FADDR_REG(FADDR_REG), .RO_REG(RO_REG)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(do_reg), .wr_sel(wr_addr[REG_MSB:ADDR_LSB]), .wr_data(wr_data),
    .flt_set(flt_set), .flt_stat(flt_stat), .flt_addr(flt_addr),
    .rd_en(rr_en), .rd_sel(rr_addr), .rd_data(rr_data),
    .tag_acc(tag_acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit <= 1'b0;
      lk_idx <= '0;
      lk_tag <= '0;
    end else if (lk_en) begin
      lk_hit <= hit_found;
      lk_idx <= hit_idx;
      lk_tag <= hit_found ? lk_key : '0;
    end
  end

  AST_FILL_FREE: assert property (@(posedge clk) disable iff (rst)
    (do_fill && inv_found)
      |=> (valid_vec[$past(inv_idx)] == $past(wr_data[VALID_BIT]))); // R3

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (do_fill && !inv_found && !unl_found)
      |=> ($stable(valid_vec) && $stable(lock_vec))); // R4

  AST_SLOT_TARGET: assert property (@(posedge clk) disable iff (rst)
    do_slot |=> (valid_vec[$past(slot_sel)] == $past(wr_data[VALID_BIT]))); // R5

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    lk_en |=> (lk_hit || (lk_tag == '0 && lk_idx == '0))); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !lk_en |=> ($stable(lk_hit) && $stable(lk_idx) && $stable(lk_tag))); // R10
endmodule

// File: tb/tlb_fill_unit_bench.sv
module tlb_fill_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] V = 64'h8000_0000_0000_0000;
  localparam logic [63:0] L = 64'h0000_0000_0000_0040;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_op = 2'b11;
  logic [8:3]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        flt_set = 1'b0;
  logic [63:0] flt_stat = '0, flt_addr = '0;
  logic        lk_en = 1'b0;
  logic [63:0] lk_key = '0;
  logic        lk_hit;
  logic [5:0]  lk_idx;
  logic [63:0] lk_tag;
  logic        rr_en = 1'b0;
  logic [6:3]  rr_addr = '0;
  logic [63:0] rr_data;
  logic        er_en = 1'b0;
  logic [5:0]  er_idx = '0;
  logic [63:0] er_tag, er_data;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_fill_unit u_tlb_fill_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_op(wr_op), .wr_addr(wr_addr),
    .wr_data(wr_data), .flt_set(flt_set), .flt_stat(flt_stat), .flt_addr(flt_addr),
    .lk_en(lk_en), .lk_key(lk_key), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_tag(lk_tag),
    .rr_en(rr_en), .rr_addr(rr_addr), .rr_data(rr_data),
    .er_en(er_en), .er_idx(er_idx), .er_tag(er_tag), .er_data(er_data));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [63:0] m_tag  [64];
  logic [63:0] m_data [64];
  bit          m_known[64];
  logic [63:0] m_reg  [16];
  logic        e_hit;
  logic [5:0]  e_idx;
  logic [63:0] e_ltag, e_rr, e_etag, e_edata;
  bit          e_eknown;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) m_data[i][63] = 1'b0;
      for (int r = 0; r < 16; r++) m_reg[r] = '0;
      e_hit = 0; e_idx = 0; e_ltag = 0; e_rr = 0; e_etag = 0; e_edata = 0;
      e_eknown = 1;
    end else begin
      if (lk_en) begin
        int where;
        where = -1;
        for (int i = 63; i >= 0; i--)
          if (m_data[i][63] && m_known[i] && m_tag[i] == lk_key) where = i;
        e_hit  = (where >= 0);
        e_idx  = (where >= 0) ? 6'(where) : 6'd0;
        e_ltag = (where >= 0) ? lk_key : 64'd0;
      end
      if (rr_en) e_rr = m_reg[rr_addr];
      if (er_en) begin
        e_eknown = m_known[er_idx];
        e_etag   = m_tag[er_idx];
        e_edata  = m_data[er_idx];
      end
      if (wr_en) begin
        case (wr_op)
          2'b00: begin
            int s;
            s = int'(wr_addr[6:3]);
            if (s == 3) begin
              if (wr_data[0]) m_reg[3] = wr_data;
              else begin m_reg[3] = 0; m_reg[4] = 0; end
            end else if (s != 0 && s != 4) m_reg[s] = wr_data;
          end
          2'b01: begin
            int slot;
            slot = -1;
            for (int i = 0; i < 64; i++)
              if (slot < 0 && !m_data[i][63]) slot = i;
            for (int i = 0; i < 64; i++)
              if (slot < 0 && !m_data[i][6]) slot = i;
            if (slot >= 0) begin
              m_tag[slot] = m_reg[6]; m_data[slot] = wr_data; m_known[slot] = 1;
            end
          end
          2'b10: begin
            m_tag[wr_addr] = m_reg[6]; m_data[wr_addr] = wr_data; m_known[wr_addr] = 1;
          end
          default: ;
        endcase
      end
      if (flt_set) begin m_reg[3] = flt_stat; m_reg[4] = flt_addr; end
    end
  end

  // Compare every output against the model on every falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      chk(lk_hit == e_hit,  "R6 search hit",   64'(lk_hit), 64'(e_hit));
      chk(lk_idx == e_idx,  "R6 search index", 64'(lk_idx), 64'(e_idx));
      chk(lk_tag == e_ltag, "R6 search tag",   lk_tag, e_ltag);
      chk(rr_data == e_rr,  "R7 register read", rr_data, e_rr);
      if (e_eknown) begin
        chk(er_tag == e_etag,   "R10 entry tag",  er_tag, e_etag);
        chk(er_data == e_edata, "R10 entry data", er_data, e_edata);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wreg(input int sel, input logic [63:0] val);
    wr_en = 1; wr_op = 2'b00; wr_addr = 6'(sel); wr_data = val;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic fill(input logic [63:0] d);
    wr_en = 1; wr_op = 2'b01; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic slot_wr(input int idx, input logic [63:0] d);
    wr_en = 1; wr_op = 2'b10; wr_addr = 6'(idx); wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic lkup(input logic [63:0] key);
    lk_en = 1; lk_key = key; @(negedge clk); lk_en = 0;
  endtask
  task automatic rreg(input int sel);
    rr_en = 1; rr_addr = 4'(sel); @(negedge clk); rr_en = 0;
  endtask
  task automatic eread(input int idx);
    er_en = 1; er_idx = 6'(idx); @(negedge clk); er_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_known[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state
    chk(lk_hit == 0 && rr_data == 0, "R1 outputs after reset", rr_data, 0);
    lkup(64'h0);
    chk(lk_hit == 0, "R1 no valid slot after reset", 64'(lk_hit), 0);
    rreg(6);
    chk(rr_data == 0, "R1 tag-access zero", rr_data, 0);
    eread(0);
    chk(er_data[63] == 0, "R2 valid bit clear after reset", 64'(er_data[63]), 0);

    // R3: fills into lowest empty slots
    wreg(6, 64'hA0); fill(V | 64'h111);
    wreg(6, 64'hB0); fill(V | 64'h222);
    wreg(6, 64'hC0); fill(V | 64'h333);
    eread(1);
    chk(er_tag == 64'hB0, "R3 second fill tag", er_tag, 64'hB0);
    chk(er_data == (V | 64'h222), "R3 second fill data", er_data, V | 64'h222);
    lkup(64'hB0);
    chk(lk_hit && lk_idx == 1, "R6 hit on slot 1", 64'(lk_idx), 1);

    // R5 / R6: duplicate tag, first match wins; invalidate and re-search
    slot_wr(5, V | 64'h555);
    eread(5);
    chk(er_tag == 64'hC0, "R5 slot write uses tag-access", er_tag, 64'hC0);
    lkup(64'hC0);
    chk(lk_idx == 2, "R6 lowest of duplicate tags", 64'(lk_idx), 2);
    slot_wr(2, 64'h0);
    lkup(64'hC0);
    chk(lk_hit && lk_idx == 5, "R6 invalid slot skipped", 64'(lk_idx), 5);
    wreg(6, 64'hD0); fill(V | 64'h444);
    eread(2);
    chk(er_tag == 64'hD0, "R3 refill lowest hole", er_tag, 64'hD0);
    lkup(64'hDEAD);
    chk(!lk_hit && lk_tag == 0 && lk_idx == 0, "R6 miss returns zero", lk_tag, 0);

    // R4: full table, locked except 20 and 40
    for (int i = 0; i < 64; i++) begin
      wreg(6, 64'h1000 + 64'(i));
      slot_wr(i, (i == 20 || i == 40) ? (V | 64'(i)) : (V | L | 64'(i)));
    end
    wreg(6, 64'hE1); fill(V | L | 64'h7);
    eread(20);
    chk(er_tag == 64'hE1, "R4 lowest unlocked replaced", er_tag, 64'hE1);
    wreg(6, 64'hE2); fill(V | L | 64'h8);
    eread(40);
    chk(er_tag == 64'hE2, "R4 next unlocked replaced", er_tag, 64'hE2);
    wreg(6, 64'hE3); fill(V | L | 64'h9);
    lkup(64'hE3);
    chk(lk_hit == 0, "R4 all locked fill dropped", 64'(lk_hit), 0);
    eread(0);
    chk(er_tag == 64'h1000, "R4 slot 0 kept", er_tag, 64'h1000);

    // R5: no-operation code leaves table alone
    wr_en = 1; wr_op = 2'b11; wr_addr = 6'd0; wr_data = 64'h0;
    @(negedge clk); wr_en = 0;
    eread(0);
    chk(er_data == (V | L), "R5 op 11 ignored", er_data, V | L);

    // R7: register selection and ignored registers
    wreg(0, 64'hFFFF); rreg(0);
    chk(rr_data == 0, "R7 register 0 ignores writes", rr_data, 0);
    wreg(4, 64'h55); rreg(4);
    chk(rr_data == 0, "R7 register 4 ignores writes", rr_data, 0);
    wreg(9, 64'h77); rreg(9);
    chk(rr_data == 64'h77, "R7 general register", rr_data, 64'h77);

    // R9: fault report beats software write
    flt_set = 1; flt_stat = 64'h5; flt_addr = 64'h1234;
    wreg(3, 64'h101);
    flt_set = 0;
    rreg(3);
    chk(rr_data == 64'h5, "R9 fault status loaded", rr_data, 64'h5);
    rreg(4);
    chk(rr_data == 64'h1234, "R9 fault address loaded", rr_data, 64'h1234);

    // R8: fault status write rules
    wreg(3, 64'h81); rreg(3);
    chk(rr_data == 64'h81, "R8 bit0 set stores", rr_data, 64'h81);
    rreg(4);
    chk(rr_data == 64'h1234, "R8 address kept", rr_data, 64'h1234);
    wreg(3, 64'h80); rreg(3);
    chk(rr_data == 0, "R8 bit0 clear zeroes status", rr_data, 0);
    rreg(4);
    chk(rr_data == 0, "R8 bit0 clear zeroes address", rr_data, 0);

    // Random mix, checked by the model on every clock (R3-R10)
    for (int n = 0; n < 600; n++) begin
      wr_en   = ($urandom % 4) != 0;
      wr_op   = 2'($urandom);
      wr_addr = 6'($urandom);
      wr_data = {1'($urandom), 56'($urandom), 1'($urandom), 6'($urandom)};
      if (wr_op == 2'b00 && ($urandom % 2)) begin
        wr_addr = 6'd6; wr_data = 64'($urandom % 8);
      end
      flt_set  = ($urandom % 16) == 0;
      flt_stat = 64'($urandom); flt_addr = 64'($urandom);
      lk_en  = ($urandom % 2); lk_key = 64'($urandom % 8);
      rr_en  = ($urandom % 2); rr_addr = 4'($urandom);
      er_en  = ($urandom % 2); er_idx = 6'($urandom);
      @(negedge clk);
    end
    wr_en = 0; flt_set = 0; lk_en = 0; rr_en = 0; er_en = 0;
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule